// File: doc/BRIEF.md
# LCD Driver Drive-Time Controller

This block sits beside an LCD segment and common waveform generator. It produces the enable that turns the LCD output drivers on after each voltage transition. The length of each enable pulse comes from a 3-bit drive-time code. The pulse counts a 1 µs tick to reach a nominal on-time. It always ends at the next level change of the prescaled LCD clock, which caps it at half of that clock's period. Static bias or blanking switches the pulse to the half-period length regardless of the code. A force bit holds the drivers on permanently.

The block also holds the contrast level shown to the analog side. A new contrast code is taken from the configuration byte only when a frame-start strobe is seen. The configuration byte is an input owned by the surrounding register logic. Its layout is: bits 7:5 are the drive-time code, bit 4 is the force-on flag, and bits 3:0 are the contrast code.

Top module: `lcd_drive_ctrl`

## Requirements
- R1: After reset, with a zero configuration byte, `drv_en_o` is 0 and `contrast_o` is 0.
- R2: A `trans_i` sampled high at a clock edge makes `drv_en_o` high from that edge onward.
- R3: With static bias and blanking low and the prescaled clock steady, drive-time codes 000, 001, 010, 011, 100, 101 and 110 end the pulse at the edge that samples the 300th, 70th, 150th, 450th, 575th, 850th and 1150th `us_tick_i` respectively. Ticks are counted after the starting edge.
- R4: Drive-time code 111 uses no tick limit; the pulse ends only at the next prescaled-clock level change.
- R5: An active pulse ends at the first clock edge, other than its starting edge, at which `lcd_ps_clk_i` differs from its value at the previous edge. When the transition is aligned with a prescaled-clock change, the pulse lasts exactly one half period even if the nominal time is longer.
- R6: If `static_bias_i` or `blank_i` is high when the transition is sampled, the pulse ignores the tick limit and ends at the next prescaled-clock level change.
- R7: While configuration bit 4 is 1, `drv_en_o` is 1 continuously, with or without transitions, bias or blanking.
- R8: A `trans_i` during an active pulse restarts the tick count, so the pulse runs a full nominal time from the new transition.
- R9: The drive-time code, bias and blanking are captured at the transition. A code change during a pulse applies only from the next transition.
- R10: `contrast_o` loads configuration bits 3:0 at the edge that samples `frame_start_i` high and holds otherwise. It is 0 from reset until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcd_ps_clk_i | input | 1 | Prescaled LCD clock level, synchronous to clk_i |
| us_tick_i | input | 1 | One-cycle strobe every microsecond |
| trans_i | input | 1 | Voltage transition strobe from the waveform generator |
| frame_start_i | input | 1 | Frame start strobe |
| static_bias_i | input | 1 | Static bias mode active |
| blank_i | input | 1 | Display blanking active |
| cfg_i | input | 8 | Configuration byte: [7:5] drive code, [4] force on, [3:0] contrast |
| drv_en_o | output | 1 | LCD driver enable |
| contrast_o | output | 4 | Active contrast code |

## Verification
The bench measures every tick-limited code by counting the ticks seen while the enable is high. An off-by-one in the terminal compare or a swapped table entry would shift that count. Transitions are aligned with prescaled-clock changes to check that long codes, code 111, bias and blanking all end after exactly one half period. A design that ignored the cap or the override flags would run long. A design that let the restart edge end the pulse would run too short. A mid-pulse restart must give a full new nominal time, and a mid-pulse code change must not cut the running pulse. Contrast is checked to stay put between frame starts and to stay zero before the first one; a design that loaded it straight through would fail both checks.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  typedef struct packed {
    logic [2:0] dt_code;
    logic       force_on;
    logic [3:0] contrast;
  } lcd_cfg_t;

  localparam logic [2:0] DT_HALF_ONLY = 3'b111;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_ps_edge.sv
module lcd_ps_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps_i,
  output logic edge_o
);
  logic ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= 1'b0;
    else         ps_q <= ps_i;
  end

  // either level change marks a half period boundary
  assign edge_o = ps_i ^ ps_q;
endmodule

// File: rtl/lcd_pulse_timer.sv
module lcd_pulse_timer #(
  parameter int unsigned T_C0_US = 300,
  parameter int unsigned T_C1_US = 70,
  parameter int unsigned T_C2_US = 150,
  parameter int unsigned T_C3_US = 450,
  parameter int unsigned T_C4_US = 575,
  parameter int unsigned T_C5_US = 850,
  parameter int unsigned T_C6_US = 1150,
  parameter int unsigned CNT_W   = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trans_i,
  input  logic       tick_i,
  input  logic       half_edge_i,
  input  logic [2:0] code_i,
  input  logic       half_only_i,
  output logic       active_o
);
  import lcd_drv_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active_q, hold_q;
  logic [CNT_W-1:0] cnt_q, lim_q, lim_sel, cnt_nxt;
  logic             hold_sel;

  always_comb begin
    unique case (code_i)
      3'd0:    lim_sel = CNT_W'(T_C0_US);
      3'd1:    lim_sel = CNT_W'(T_C1_US);
      3'd2:    lim_sel = CNT_W'(T_C2_US);
      3'd3:    lim_sel = CNT_W'(T_C3_US);
      3'd4:    lim_sel = CNT_W'(T_C4_US);
      3'd5:    lim_sel = CNT_W'(T_C5_US);
      3'd6:    lim_sel = CNT_W'(T_C6_US);
      default: lim_sel = '1;
    endcase
  end

  assign hold_sel = half_only_i | (code_i == DT_HALF_ONLY);
  assign cnt_nxt  = (cnt_q == '1) ? cnt_q : cnt_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else if (trans_i) begin
      active_q <= 1'b1;
      hold_q   <= hold_sel;
      cnt_q    <= '0;
      lim_q    <= lim_sel;
    end else if (active_q) begin
      if (half_edge_i) begin
        active_q <= 1'b0;
      end else if (tick_i) begin
        cnt_q <= cnt_nxt;
        if (!hold_q && cnt_nxt >= lim_q) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_i |=> active_q);
  a_r5_half_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_edge_i && !trans_i) |=> !active_q);
  a_r6_hold_ignores_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && hold_q && tick_i && !half_edge_i && !trans_i) |=> active_q);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !hold_q) |-> (cnt_q < lim_q));
  a_r9_limit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trans_i |=> $stable(lim_q));
endmodule

// File: rtl/lcd_contrast_shadow.sv
module lcd_contrast_shadow #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] wr_i,
  output logic [CW-1:0] act_o
);
  logic [CW-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= wr_i;
  end

  assign act_o = act_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_q == $past(wr_i)));
endmodule

// File: rtl/lcd_drive_ctrl.sv
module lcd_drive_ctrl #(
  parameter int unsigned T_C0_US = 300,
  parameter int unsigned T_C1_US = 70,
  parameter int unsigned T_C2_US = 150,
  parameter int unsigned T_C3_US = 450,
  parameter int unsigned T_C4_US = 575,
  parameter int unsigned T_C5_US = 850,
  parameter int unsigned T_C6_US = 1150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lcd_ps_clk_i,
  input  logic       us_tick_i,
  input  logic       trans_i,
  input  logic       frame_start_i,
  input  logic       static_bias_i,
  input  logic       blank_i,
  input  logic [7:0] cfg_i,
  output logic       drv_en_o,
  output logic [3:0] contrast_o
);
  import lcd_drv_pkg::*;

  localparam int unsigned T_MAX = max2(max2(max2(T_C0_US, T_C1_US), max2(T_C2_US, T_C3_US)),
                                       max2(max2(T_C4_US, T_C5_US), T_C6_US));
  localparam int unsigned CNT_W = $clog2(T_MAX + 2);

  lcd_cfg_t cfg;
  logic     half_edge, pulse_act;

  assign cfg = lcd_cfg_t'(cfg_i);

  lcd_ps_edge u_ps_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ps_i   (lcd_ps_clk_i),
    .edge_o (half_edge)
  );

  lcd_pulse_timer #(
    .T_C0_US (T_C0_US), .T_C1_US (T_C1_US), .T_C2_US (T_C2_US),
    .T_C3_US (T_C3_US), .T_C4_US (T_C4_US), .T_C5_US (T_C5_US),
    .T_C6_US (T_C6_US), .CNT_W   (CNT_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trans_i     (trans_i),
    .tick_i      (us_tick_i),
    .half_edge_i (half_edge),
    .code_i      (cfg.dt_code),
    .half_only_i (static_bias_i | blank_i),
    .active_o    (pulse_act)
  );

  lcd_contrast_shadow #(.CW(4)) u_contrast (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_start_i),
    .wr_i   (cfg.contrast),
    .act_o  (contrast_o)
  );

  assign drv_en_o = pulse_act | cfg.force_on;

  a_r7_force_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[4] && $past(cfg_i[4])) |-> drv_en_o);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[4] && !$past(trans_i) && !$past(drv_en_o)) |-> !drv_en_o);
endmodule

// File: tb/lcd_drive_ctrl_tb.sv
module lcd_drive_ctrl_tb;
  localparam int HALF = 200;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ps = 1'b0, tick = 1'b0, trans = 1'b0, frame = 1'b0;
  logic       bias = 1'b0, blank = 1'b0, tick_run = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       drv_en;
  logic [3:0] contrast;
  int         errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tick <= tick_run ? ~tick : 1'b0;

  lcd_drive_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_n), .lcd_ps_clk_i (ps), .us_tick_i (tick),
    .trans_i (trans), .frame_start_i (frame), .static_bias_i (bias),
    .blank_i (blank), .cfg_i (cfg), .drv_en_o (drv_en), .contrast_o (contrast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // raise trans in a cycle without a tick; returns 1 ns after the start edge's negedge
  task automatic fire_trans();
    @(negedge clk);
    while (tick !== 1'b1) @(negedge clk);
    trans = 1'b1;
    @(negedge clk);
    trans = 1'b0;
    #1;
  endtask

  task automatic count_ticks(output int n);
    int guard = 0;
    n = 0;
    while (drv_en && guard < 6000) begin
      if (tick) n++;
      @(negedge clk); #1;
      guard++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(drv_en == 1'b0, "R1 drv_en", drv_en, 0);
    check(contrast == 4'd0, "R1 contrast", contrast, 0);
  endtask

  task automatic t_code(input logic [2:0] code, input int exp);
    int n;
    cfg[7:5] = code;
    fire_trans();
    check(drv_en == 1'b1, "R2 start", drv_en, 1);
    count_ticks(n);
    check(n == exp, $sformatf("R3 code %0d ticks", code), n, exp);
  endtask

  // transition aligned with a prescaled clock change; expect HALF cycles high
  task automatic t_half(input logic [2:0] code, input logic b, input logic k, input string req);
    int high = 0;
    cfg[7:5] = code;
    bias = b; blank = k;
    @(negedge clk);
    ps = ~ps; trans = 1'b1;
    for (int i = 1; i <= HALF + 3; i++) begin
      @(negedge clk);
      trans = 1'b0;
      if (i == HALF) ps = ~ps;
      #1;
      if (drv_en) high++;
    end
    check(high == HALF, req, high, HALF);
    bias = 1'b0; blank = 1'b0;
  endtask

  task automatic t_force();
    int low = 0;
    cfg[4] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 10) ps = ~ps;
      if (i == 20) blank = 1'b1;
      #1;
      if (!drv_en) low++;
    end
    check(low == 0, "R7 force on", low, 0);
    blank = 1'b0;
    cfg[4] = 1'b0;
    @(negedge clk); #1;
    check(drv_en == 1'b0, "R7 release", drv_en, 0);
  endtask

  task automatic t_restart();
    int n = 0;
    cfg[7:5] = 3'b001;
    fire_trans();
    while (n < 30) begin
      if (tick) n++;
      @(negedge clk); #1;
    end
    fire_trans();
    check(drv_en == 1'b1, "R8 still on", drv_en, 1);
    count_ticks(n);
    check(n == 70, "R8 restart ticks", n, 70);
  endtask

  task automatic t_midchange();
    int n = 0, rest;
    cfg[7:5] = 3'b010;
    fire_trans();
    while (n < 20) begin
      if (tick) n++;
      @(negedge clk); #1;
    end
    cfg[7:5] = 3'b001;
    count_ticks(rest);
    check(n + rest == 150, "R9 old code kept", n + rest, 150);
    fire_trans();
    count_ticks(n);
    check(n == 70, "R9 new code next", n, 70);
  endtask

  task automatic t_contrast();
    cfg[3:0] = 4'h5;
    repeat (3) @(negedge clk);
    #1;
    check(contrast == 4'h0, "R10 zero before frame", contrast, 0);
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0; #1;
    check(contrast == 4'h5, "R10 load", contrast, 5);
    cfg[3:0] = 4'hA;
    repeat (4) @(negedge clk);
    #1;
    check(contrast == 4'h5, "R10 hold", contrast, 5);
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0; #1;
    check(contrast == 4'hA, "R10 reload", contrast, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_contrast();
    tick_run = 1'b1;
    repeat (4) @(negedge clk);
    t_code(3'b000, 300);
    t_code(3'b001, 70);
    t_code(3'b010, 150);
    t_code(3'b011, 450);
    t_code(3'b100, 575);
    t_code(3'b101, 850);
    t_code(3'b110, 1150);
    t_half(3'b111, 1'b0, 1'b0, "R4 code 111 half");
    t_half(3'b110, 1'b0, 1'b0, "R5 cap at half");
    t_half(3'b001, 1'b1, 1'b0, "R6 static bias");
    t_half(3'b001, 1'b0, 1'b1, "R6 blanking");
    t_force();
    t_restart();
    t_midchange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule